// File: doc/BRIEF.md
# Floating-Point Register Store Unit

This block executes a single floating-point register store instruction. It takes a 32-bit instruction word together with context flags: which encoding form the word came from, whether the instruction's condition passed, whether the floating-point unit is enabled, whether half-precision is supported, the current data endianness, and whether the word sits inside a predicated block. The block checks the word for legality. It reads the named register through a single register-file read port, forms the effective address from a base value and a scaled immediate, and issues the data on a 32-bit word-oriented write port that uses a valid/ready handshake.

The block can store a half-precision, single-precision or double-precision value. A double-precision value is written as two word beats, one at the effective address and one at the effective address plus 4. The current endianness decides which half of the register goes to which address.

The legality outcome is reported in the same cycle that the instruction is accepted. It is either an undefined flag or an unpredictable flag. When either flag is raised, nothing is written. Instructions are accepted only while the block is idle.

Top module: `fpst_unit`

## Requirements
- R1: An instruction is accepted in a cycle where `in_valid` is high and `busy` is low. After accepting a storing instruction, `busy` is high from the next cycle until the last write beat is taken. While `busy` is high, `in_valid` has no effect, and no flag is raised.
- R2: `flag_undef` is raised in the accept cycle, and no write follows, in any of these cases:
  - bits 27:24 are not 1101;
  - bits 21:20 are not 00;
  - bits 11:10 are not 10;
  - the conditional form (`in_compact`=0) has bits 31:28 = 1111;
  - the compact form (`in_compact`=1) has bits 31:28 other than 1110;
  - the size field (bits 9:8) is 00.
- R3: `flag_undef` is also raised in two more cases. The first is a half-precision store (size 01) when `in_half_ok` is low or the parameter HALF_SUPPORT is 0. The second is when `in_cond_pass` is high and `in_fp_en` is low.
- R4: `flag_unpred` is raised, and no write follows, in three cases:
  - a half-precision store in the conditional form whose bits 31:28 are not 1110;
  - a half-precision store in the compact form while `in_pred_blk` is high;
  - a compact-form store whose base register field (bits 19:16) is 15.
  `flag_unpred` is never high together with `flag_undef`, which takes priority.
- R5: When `in_cond_pass` is low, no write is issued and `busy` stays low. Only the encoding checks of R2 and R4 and the half-precision support check of R3 can raise a flag in that case.
- R6: The effective address is the base plus the offset when bit 23 is 1, and the base minus the offset when bit 23 is 0, computed modulo 2^ADDR_W. The offset is bits 7:0 shifted left by 1 for size 01, and shifted left by 2 for sizes 10 and 11.
- R7: For sizes 01 and 10, `rf_idx` is {bits 15:12, bit 22} and `rf_dbl` is 0. For size 11, `rf_idx` is {bit 22, bits 15:12} and `rf_dbl` is 1.
- R8: A half-precision store writes one beat. The data carries `rf_rdata[15:0]` in both halves. The strobe is 0011 when bit 1 of the address is 0, and 1100 when it is 1.
- R9: A single-precision store writes one beat with data `rf_rdata[31:0]` and strobe 1111.
- R10: A double-precision store writes two beats with strobe 1111, first to the effective address and then to the effective address plus 4. With `in_big_end` low, the first beat carries `rf_rdata[31:0]` and the second carries `rf_rdata[63:32]`. With `in_big_end` high, the order of the two data words is reversed.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_data` and `mem_strb` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction presented |
| in_instr | input | 32 | Instruction word |
| in_compact | input | 1 | 1 = compact form, 0 = conditional form |
| in_pred_blk | input | 1 | Compact-form word lies inside a predicated block |
| in_cond_pass | input | 1 | Instruction condition passed |
| in_fp_en | input | 1 | Floating-point unit enabled |
| in_half_ok | input | 1 | Half-precision support present |
| in_big_end | input | 1 | Big-endian data order |
| in_base | input | ADDR_W | Base register value |
| rf_idx | output | 5 | Register-file read index |
| rf_dbl | output | 1 | Register-file read is a 64-bit register |
| rf_rdata | input | 64 | Register-file read data (single value in bits 31:0) |
| busy | output | 1 | Write beats pending |
| flag_undef | output | 1 | Undefined instruction, accept cycle |
| flag_unpred | output | 1 | Unpredictable instruction, accept cycle |
| mem_valid | output | 1 | Write beat valid |
| mem_ready | input | 1 | Write beat taken |
| mem_addr | output | ADDR_W | Write byte address |
| mem_data | output | 32 | Write data |
| mem_strb | output | 4 | Byte strobes |

## Verification
The functions that can share a cycle are instruction acceptance, with its legality flags, and a pending write beat of an earlier double-precision store. The bench provokes the overlap by presenting an illegal word with `in_valid` high while a beat is stalled by a low `mem_ready`. It then judges that no flag rises and that the stalled beat stays unchanged. In the same stalled cycle the bench also confirms that the beat's address, data and strobe are held for the full stall.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
   typedef enum logic [1:0] {
      SZ_BAD    = 2'b00,
      SZ_HALF   = 2'b01,
      SZ_SINGLE = 2'b10,
      SZ_DOUBLE = 2'b11
   } elem_sz_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_BEAT0 = 2'b01,
      ST_BEAT1 = 2'b10
   } wseq_st_t;

   localparam int unsigned INSTR_W = 32;
   localparam int unsigned WORD_W  = 32;
   localparam int unsigned IDX_W   = 5;
endpackage

// File: rtl/fpst_decode.sv
module fpst_decode
   import fpst_pkg::*;
#(
   parameter bit HALF_SUPPORT = 1'b1
) (
   input  logic [INSTR_W-1:0] instr,
   input  logic               compact,
   input  logic               pred_blk,
   input  logic               cond_pass,
   input  logic               fp_en,
   input  logic               half_ok,
   output logic               undef,
   output logic               unpred,
   output elem_sz_t           esz,
   output logic               add,
   output logic [9:0]         off,
   output logic [IDX_W-1:0]   idx,
   output logic               dbl
);
   logic       half_avail;
   logic       fixed_ok;
   logic       enc_undef;
   logic       unpred_raw;
   logic [3:0] cond_f;
   logic [3:0] rn_f;
   logic [3:0] vd_f;
   logic       d_f;
   logic [7:0] imm_f;

   generate
      if (HALF_SUPPORT) begin : g_half
         assign half_avail = half_ok;
      end else begin : g_nohalf
         assign half_avail = 1'b0;
      end
   endgenerate

   always_comb begin
      cond_f = instr[31:28];
      rn_f   = instr[19:16];
      vd_f   = instr[15:12];
      d_f    = instr[22];
      imm_f  = instr[7:0];
      esz    = elem_sz_t'(instr[9:8]);
      add    = instr[23];
      fixed_ok = (instr[27:24] == 4'b1101) && (instr[21:20] == 2'b00)
              && (instr[11:10] == 2'b10)
              && (compact ? (cond_f == 4'b1110) : (cond_f != 4'b1111));
      enc_undef = !fixed_ok || (esz == SZ_BAD) || ((esz == SZ_HALF) && !half_avail);
      undef  = enc_undef || (cond_pass && !fp_en);
      unpred_raw = ((esz == SZ_HALF) && (compact ? pred_blk : (cond_f != 4'b1110)))
                || (compact && (rn_f == 4'hF));
      unpred = !undef && unpred_raw;
      off    = (esz == SZ_HALF) ? {1'b0, imm_f, 1'b0} : {imm_f, 2'b00};
      dbl    = (esz == SZ_DOUBLE);
      idx    = dbl ? {d_f, vd_f} : {vd_f, d_f};
   end
endmodule

// File: rtl/fpst_agen.sv
module fpst_agen #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic              add,
   input  logic [9:0]        off,
   output logic [ADDR_W-1:0] addr
);
   localparam int unsigned PAD_W = ADDR_W - 10;
   logic [ADDR_W-1:0] off_ext;

   assign off_ext = {{PAD_W{1'b0}}, off};
   assign addr    = add ? (base + off_ext) : (base - off_ext);
endmodule

// File: rtl/fpst_wseq.sv
module fpst_wseq
   import fpst_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  elem_sz_t          esz,
   input  logic              big_end,
   input  logic [ADDR_W-1:0] addr,
   input  logic [63:0]       rdata,
   output logic              busy,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_data,
   output logic [3:0]        mem_strb
);
   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

   wseq_st_t          st;
   logic [ADDR_W-1:0] a0_q;
   logic [WORD_W-1:0] d0_q;
   logic [WORD_W-1:0] d1_q;
   logic [3:0]        s0_q;
   logic              two_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         a0_q  <= '0;
         d0_q  <= '0;
         d1_q  <= '0;
         s0_q  <= '0;
         two_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st    <= ST_BEAT0;
               a0_q  <= addr;
               two_q <= (esz == SZ_DOUBLE);
               case (esz)
                  SZ_HALF: begin
                     d0_q <= {2{rdata[15:0]}};
                     s0_q <= addr[1] ? 4'b1100 : 4'b0011;
                  end
                  SZ_DOUBLE: begin
                     d0_q <= big_end ? rdata[63:32] : rdata[31:0];
                     d1_q <= big_end ? rdata[31:0]  : rdata[63:32];
                     s0_q <= 4'b1111;
                  end
                  default: begin
                     d0_q <= rdata[31:0];
                     s0_q <= 4'b1111;
                  end
               endcase
            end
            ST_BEAT0: if (mem_ready) st <= two_q ? ST_BEAT1 : ST_IDLE;
            ST_BEAT1: if (mem_ready) st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st != ST_IDLE);
   assign mem_valid = busy;
   assign mem_addr  = (st == ST_BEAT1) ? (a0_q + WORD_STEP) : a0_q;
   assign mem_data  = (st == ST_BEAT1) ? d1_q : d0_q;
   assign mem_strb  = (st == ST_BEAT1) ? 4'b1111 : s0_q;
endmodule

// File: rtl/fpst_unit.sv
module fpst_unit
   import fpst_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter bit          HALF_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       in_instr,
   input  logic              in_compact,
   input  logic              in_pred_blk,
   input  logic              in_cond_pass,
   input  logic              in_fp_en,
   input  logic              in_half_ok,
   input  logic              in_big_end,
   input  logic [ADDR_W-1:0] in_base,
   output logic [4:0]        rf_idx,
   output logic              rf_dbl,
   input  logic [63:0]       rf_rdata,
   output logic              busy,
   output logic              flag_undef,
   output logic              flag_unpred,
   output logic              mem_valid,
   input  logic              mem_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_data,
   output logic [3:0]        mem_strb
);
   generate
      if (ADDR_W < 12 || ADDR_W > 64) begin : g_bad_addr_w
         $error("fpst_unit: ADDR_W must lie in 12..64");
      end
      if (INSTR_W != 32 || WORD_W != 32 || IDX_W != 5) begin : g_bad_pkg
         $error("fpst_unit: package widths out of range");
      end
   endgenerate

   logic              dec_undef;
   logic              dec_unpred;
   elem_sz_t          dec_esz;
   logic              dec_add;
   logic [9:0]        dec_off;
   logic [ADDR_W-1:0] eff_addr;
   logic              accept;
   logic              start;

   fpst_decode #(.HALF_SUPPORT(HALF_SUPPORT)) dec_i (
      .instr     (in_instr),
      .compact   (in_compact),
      .pred_blk  (in_pred_blk),
      .cond_pass (in_cond_pass),
      .fp_en     (in_fp_en),
      .half_ok   (in_half_ok),
      .undef     (dec_undef),
      .unpred    (dec_unpred),
      .esz       (dec_esz),
      .add       (dec_add),
      .off       (dec_off),
      .idx       (rf_idx),
      .dbl       (rf_dbl)
   );

   fpst_agen #(.ADDR_W(ADDR_W)) agen_i (
      .base (in_base),
      .add  (dec_add),
      .off  (dec_off),
      .addr (eff_addr)
   );

   assign accept      = in_valid && !busy;
   assign flag_undef  = accept && dec_undef;
   assign flag_unpred = accept && dec_unpred;
   assign start       = accept && in_cond_pass && !dec_undef && !dec_unpred;

   fpst_wseq #(.ADDR_W(ADDR_W)) wseq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .esz       (dec_esz),
      .big_end   (in_big_end),
      .addr      (eff_addr),
      .rdata     (rf_rdata),
      .busy      (busy),
      .mem_valid (mem_valid),
      .mem_ready (mem_ready),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .mem_strb  (mem_strb)
   );
endmodule

// File: rtl/fpst_chk.sv
module fpst_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              busy,
   input logic              flag_undef,
   input logic              flag_unpred,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [31:0]       mem_data,
   input logic [3:0]        mem_strb
);
   // R1
   flags_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_undef || flag_unpred) |-> (in_valid && !busy));
   // R4
   flag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_undef && flag_unpred));
   // R2
   flag_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_undef || flag_unpred) |=> !mem_valid);
   // R11
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                     && $stable(mem_data) && $stable(mem_strb)));
   // R8
   strb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_strb == 4'b0011 || mem_strb == 4'b1100 || mem_strb == 4'b1111));
   // R1
   valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> busy);
endmodule

bind fpst_unit fpst_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .busy        (busy),
   .flag_undef  (flag_undef),
   .flag_unpred (flag_unpred),
   .mem_valid   (mem_valid),
   .mem_ready   (mem_ready),
   .mem_addr    (mem_addr),
   .mem_data    (mem_data),
   .mem_strb    (mem_strb)
);

// File: tb/fpst_unit_tb_top.sv
module fpst_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic        in_compact = 1'b0;
   logic        in_pred_blk = 1'b0;
   logic        in_cond_pass = 1'b1;
   logic        in_fp_en = 1'b1;
   logic        in_half_ok = 1'b1;
   logic        in_big_end = 1'b0;
   logic [31:0] in_base = '0;
   logic [4:0]  rf_idx;
   logic        rf_dbl;
   logic [63:0] rf_rdata;
   logic        busy;
   logic        flag_undef;
   logic        flag_unpred;
   logic        mem_valid;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_addr;
   logic [31:0] mem_data;
   logic [3:0]  mem_strb;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   fpst_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .in_compact(in_compact), .in_pred_blk(in_pred_blk),
      .in_cond_pass(in_cond_pass), .in_fp_en(in_fp_en),
      .in_half_ok(in_half_ok), .in_big_end(in_big_end), .in_base(in_base),
      .rf_idx(rf_idx), .rf_dbl(rf_dbl), .rf_rdata(rf_rdata), .busy(busy),
      .flag_undef(flag_undef), .flag_unpred(flag_unpred),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_strb(mem_strb)
   );

   function automatic logic [31:0] sval(input logic [4:0] i);
      return 32'h1357_0000 + ({27'd0, i} * 32'h0001_0203) + 32'h0000_00A0;
   endfunction

   function automatic logic [63:0] dval(input logic [4:0] i);
      return {sval(i) ^ 32'hF0F0_0000, ~sval(i)};
   endfunction

   always_comb rf_rdata = rf_dbl ? dval(rf_idx) : {32'h0, sval(rf_idx)};

   function automatic logic [31:0] mk(input logic [3:0] c, input logic u, input logic d,
                                      input logic [3:0] rn, input logic [3:0] vd,
                                      input logic [1:0] sz, input logic [7:0] imm);
      return {c, 4'b1101, u, d, 2'b00, rn, vd, 2'b10, sz, imm};
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_up();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // Caller is at a negedge. Drives one instruction for one cycle and checks the flags.
   task automatic issue(input logic [31:0] ins, input logic cmp, input logic blk,
                        input logic cp, input logic fpen, input logic hok,
                        input logic big, input logic [31:0] base,
                        input logic eu, input logic ep, input string req);
      in_instr = ins; in_compact = cmp; in_pred_blk = blk; in_cond_pass = cp;
      in_fp_en = fpen; in_half_ok = hok; in_big_end = big; in_base = base;
      in_valid = 1'b1;
      #1;
      check({req, " undef"},  {63'd0, flag_undef},  {63'd0, eu});
      check({req, " unpred"}, {63'd0, flag_unpred}, {63'd0, ep});
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_none(input string req);
      check({req, " no write"}, {62'd0, mem_valid, busy}, 64'd0);
   endtask

   task automatic expect_beat(input string req, input logic [31:0] a, input logic [31:0] d,
                              input logic [3:0] s, input bit stall);
      if (stall) begin
         check({req, " busy"}, {63'd0, busy}, 64'd1);
         // R1: a word presented while busy is ignored
         in_instr = 32'h0; in_valid = 1'b1; #1;
         check("R1 ignored while busy", {62'd0, flag_undef, flag_unpred}, 64'd0);
         @(negedge clk);
         in_valid = 1'b0;
         check("R11 hold addr", {32'd0, mem_addr}, {32'd0, a});
         check("R11 hold data", {32'd0, mem_data}, {32'd0, d});
      end
      check({req, " valid"}, {63'd0, mem_valid}, 64'd1);
      check({req, " addr"},  {32'd0, mem_addr},  {32'd0, a});
      check({req, " data"},  {32'd0, mem_data},  {32'd0, d});
      check({req, " strb"},  {60'd0, mem_strb},  {60'd0, s});
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      int it;
      repeat (3) @(negedge clk);
      check("R1 reset state", {60'd0, busy, mem_valid, flag_undef, flag_unpred}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      it = 0;
      for (int sz = 1; sz <= 3; sz++) begin
         for (int u = 0; u < 2; u++) begin
            for (int dd = 0; dd < 2; dd++) begin
               for (int vd = 0; vd < 16; vd += 5) begin
                  for (int k = 0; k < 4; k++) begin
                     for (int big = 0; big < 2; big++) begin
                        logic [7:0]  imm;
                        logic [31:0] base, off, ea, ins, sv;
                        logic [63:0] dv;
                        logic [4:0]  idx;
                        logic        cmp;
                        bit          stall;
                        imm  = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 : 8'hFF;
                        base = it[0] ? (it * 6) : (32'hFFFF_FF00 + it * 6);
                        cmp  = it[1];
                        stall = (it % 3) == 0;
                        ins  = mk(cmp ? 4'b1110 : ((sz == 1) ? 4'b1110 : 4'b0000),
                                  u[0], dd[0], 4'd3, vd[3:0], sz[1:0], imm);
                        off  = (sz == 1) ? {23'd0, imm, 1'b0} : {22'd0, imm, 2'b00};
                        ea   = u[0] ? base + off : base - off;
                        idx  = (sz == 3) ? {dd[0], vd[3:0]} : {vd[3:0], dd[0]};
                        sv   = sval(idx);
                        dv   = dval(idx);
                        in_instr = ins; in_compact = cmp; #1;
                        // R7 register index and width
                        check("R7 idx", {58'd0, rf_dbl, rf_idx}, {58'd0, (sz == 3), idx});
                        issue(ins, cmp, 1'b0, 1'b1, 1'b1, 1'b1, big[0], base, 1'b0, 1'b0, "R6");
                        if (sz == 1) begin
                           // R8 half store, lanes by address bit 1
                           expect_beat("R8 half", ea, {sv[15:0], sv[15:0]},
                                       ea[1] ? 4'b1100 : 4'b0011, stall);
                        end else if (sz == 2) begin
                           // R9 single store
                           expect_beat("R9 single", ea, sv, 4'b1111, stall);
                        end else begin
                           // R10 double store order follows endianness
                           expect_beat("R10 dbl first", ea, big ? dv[63:32] : dv[31:0], 4'b1111, stall);
                           expect_beat("R10 dbl second", ea + 32'd4, big ? dv[31:0] : dv[63:32], 4'b1111, stall);
                        end
                        expect_none("R1 idle after beats");
                        it++;
                     end
                  end
               end
            end
         end
      end

      // R2 encoding faults
      issue(mk(4'b1110, 1, 0, 1, 2, 2, 8'h10) ^ 32'h0100_0000, 0, 0, 1, 1, 1, 0, 32'h100, 1, 0, "R2 opcode");
      expect_none("R2 opcode");
      issue(mk(4'b1110, 1, 0, 1, 2, 2, 8'h10) | 32'h0010_0000, 0, 0, 1, 1, 1, 0, 32'h100, 1, 0, "R2 bits21:20");
      expect_none("R2 bits21:20");
      issue(mk(4'b1110, 1, 0, 1, 2, 2, 8'h10) ^ 32'h0000_0C00, 0, 0, 1, 1, 1, 0, 32'h100, 1, 0, "R2 bits11:10");
      expect_none("R2 bits11:10");
      issue(mk(4'b1111, 1, 0, 1, 2, 2, 8'h10), 0, 0, 1, 1, 1, 0, 32'h100, 1, 0, "R2 cond 1111");
      expect_none("R2 cond 1111");
      issue(mk(4'b0000, 1, 0, 1, 2, 2, 8'h10), 1, 0, 1, 1, 1, 0, 32'h100, 1, 0, "R2 compact top");
      expect_none("R2 compact top");
      issue(mk(4'b1110, 1, 0, 1, 2, 0, 8'h10), 0, 0, 1, 1, 1, 0, 32'h100, 1, 0, "R2 size 00");
      expect_none("R2 size 00");
      // R3 support and enable
      issue(mk(4'b1110, 1, 0, 1, 2, 1, 8'h10), 0, 0, 1, 1, 0, 0, 32'h100, 1, 0, "R3 no half");
      expect_none("R3 no half");
      issue(mk(4'b1110, 1, 0, 1, 2, 3, 8'h10), 0, 0, 1, 0, 1, 0, 32'h100, 1, 0, "R3 fp off");
      expect_none("R3 fp off");
      // R4 unpredictable cases and priority
      issue(mk(4'b0001, 1, 0, 1, 2, 1, 8'h10), 0, 0, 1, 1, 1, 0, 32'h100, 0, 1, "R4 half cond");
      expect_none("R4 half cond");
      issue(mk(4'b1110, 1, 0, 1, 2, 1, 8'h10), 1, 1, 1, 1, 1, 0, 32'h100, 0, 1, "R4 half in block");
      expect_none("R4 half in block");
      issue(mk(4'b1110, 1, 0, 4'hF, 2, 2, 8'h10), 1, 0, 1, 1, 1, 0, 32'h100, 0, 1, "R4 base 15");
      expect_none("R4 base 15");
      issue(mk(4'b1110, 1, 0, 4'hF, 2, 0, 8'h10), 1, 0, 1, 1, 1, 0, 32'h100, 1, 0, "R4 undef priority");
      expect_none("R4 undef priority");
      // R5 condition failed
      issue(mk(4'b0000, 1, 0, 1, 2, 2, 8'h10), 0, 0, 0, 1, 1, 0, 32'h100, 0, 0, "R5 cond fail");
      expect_none("R5 cond fail");
      issue(mk(4'b0000, 1, 0, 1, 2, 3, 8'h10), 0, 0, 0, 0, 1, 0, 32'h100, 0, 0, "R5 cond fail fp off");
      expect_none("R5 cond fail fp off");
      issue(mk(4'b1110, 1, 0, 1, 2, 0, 8'h10), 0, 0, 0, 1, 1, 0, 32'h100, 1, 0, "R5 cond fail enc");
      expect_none("R5 cond fail enc");
      finish_up();
   end
endmodule